// File: doc/BRIEF.md
# Downstream I/O Forwarding Router

This block sits at the downstream end of an I/O hub. Each request arrives with its routing attribute already assigned. The attribute is one of four values: do-not-decode, display-adapter (VGA), compatibility bus, or reserved. The request also carries an address, a direction and a kind (I/O or configuration). The router either picks one of up to four downstream links and pulses a forward strobe with that link index, or it pulses a master-abort strobe so that the completion logic can return an abort.

Each attribute has its own target and its own abort condition:

- A VGA request uses the VGA link field. It is aborted when that field is marked not valid.
- A compatibility request uses the compatibility link. It is aborted when the compatibility enable is clear.
- A do-not-decode request uses the link of a single I/O window. It is aborted when its address lies outside that window.

Inbound I/O is always aborted, because peer-to-peer I/O is not supported. Configuration cycles are also always aborted, because nothing behind the downstream links accepts them. Software is expected to program the window so that the lowest 4 KB of I/O space (addresses below 1000h) lands on the link that carries the compatibility bus.

The control fields are sampled in the same cycle as the request. A request can be accepted on every clock. The decision is held in a three-state register: `RS_IDLE`, `RS_FWD` or `RS_ABORT`. The request is accepted on the edge where `req_valid` is high. On that edge the state moves to `RS_FWD` if the request is forwarded and to `RS_ABORT` if it is aborted. On an edge where `req_valid` is low, the state returns to `RS_IDLE`. The strobes are decoded from the state, so each one appears in the cycle after acceptance.

Top module: `ioroute_top`

## Requirements
- R1: While reset is held and in the first cycle after reset, `fwd_stb` and `abort_stb` are low and `fwd_link` is 0.
- R2: For every cycle in which `req_valid` is high, exactly one of `fwd_stb` and `abort_stb` is high in the following cycle. After a cycle with `req_valid` low, both strobes are low.
- R3: A request with `req_inbound`=1 is aborted, whatever its attribute and control fields.
- R4: A request with `req_cfg`=1 (configuration cycle) is aborted, whatever its attribute and control fields.
- R5: An outbound I/O request with `req_attr`=01 (VGA) and `vga_link_vld`=1 is forwarded with `fwd_link` equal to `vga_link`.
- R6: An outbound I/O request with `req_attr`=01 and `vga_link_vld`=0 is aborted.
- R7: An outbound I/O request with `req_attr`=10 (compatibility) and `cb_en`=1 is forwarded with `fwd_link` equal to `cb_link`.
- R8: An outbound I/O request with `req_attr`=10 and `cb_en`=0 is aborted.
- R9: An outbound I/O request with `req_attr`=00 (do-not-decode) is forwarded to `win_link` when address bits [15:12] lie in the inclusive range from `win_base` to `win_limit`. With `win_base`=0, addresses below 1000h are therefore forwarded to `win_link`.
- R10: An outbound I/O request with `req_attr`=00 whose address bits [15:12] are below `win_base` or above `win_limit` is aborted. When `win_base` is greater than `win_limit`, the window is empty.
- R11: An outbound I/O request with `req_attr`=11 (reserved) is aborted.
- R12: `fwd_link` is 0 in every cycle in which `fwd_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented and accepted this cycle |
| req_attr | input | 2 | Routing attribute: 00 do-not-decode, 01 VGA, 10 compatibility, 11 reserved |
| req_addr | input | 16 | I/O address |
| req_inbound | input | 1 | 1 when the request travels inbound |
| req_cfg | input | 1 | 1 for a configuration cycle, 0 for I/O |
| vga_link | input | 2 | Link that carries VGA traffic |
| vga_link_vld | input | 1 | VGA link is defined |
| cb_en | input | 1 | Compatibility bus enable |
| cb_link | input | 2 | Link that carries the compatibility bus |
| win_base | input | 4 | Window base, in 4 KB blocks (address bits [15:12]) |
| win_limit | input | 4 | Window limit, in 4 KB blocks, inclusive |
| win_link | input | 2 | Link that serves the I/O window |
| fwd_stb | output | 1 | Forward strobe, one cycle per forwarded request |
| fwd_link | output | 2 | Target link of the forward |
| abort_stb | output | 1 | Master-abort strobe, one cycle per aborted request |

## Verification
The assertions assume that every input has a known value at each rising edge while reset is released. They also assume that the control fields belong to the request of the same cycle, so the previous-cycle values they compare against are the ones the decision used. The assertions make no assumption about request spacing or about which attribute values are used. The stimulus drives every input to a defined value on the falling edge. It picks new random control fields for each request and puts idle cycles between some requests. Directed cases place addresses exactly on the window edges and one block outside them, and also cover the empty window.

// File: rtl/ioroute_pkg.sv
package ioroute_pkg;

    typedef enum logic [1:0] {
        ATTR_DND  = 2'b00,
        ATTR_VGA  = 2'b01,
        ATTR_CB   = 2'b10,
        ATTR_RSVD = 2'b11
    } route_attr_t;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'b00,
        RS_FWD   = 2'b01,
        RS_ABORT = 2'b10
    } route_state_t;

endpackage

// File: rtl/ioroute_window.sv
module ioroute_window #(
    parameter int ADDR_W    = 16,
    parameter int BLK_SHIFT = 12,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BLK_W-1:0]  base_blk,
    input  logic [BLK_W-1:0]  limit_blk,
    output logic              hit
);

    logic [BLK_W-1:0] addr_blk;

    always_comb begin
        addr_blk = addr[ADDR_W-1:BLK_SHIFT];
        hit      = (addr_blk >= base_blk) && (addr_blk <= limit_blk);
    end

endmodule

// File: rtl/ioroute_select.sv
module ioroute_select
    import ioroute_pkg::*;
#(
    parameter int LINK_W = 2
) (
    input  route_attr_t       attr,
    input  logic              inbound,
    input  logic              is_cfg,
    input  logic [LINK_W-1:0] vga_link,
    input  logic              vga_link_vld,
    input  logic              cb_en,
    input  logic [LINK_W-1:0] cb_link,
    input  logic              win_hit,
    input  logic [LINK_W-1:0] win_link,
    output logic              go_fwd,
    output logic [LINK_W-1:0] link
);

    logic              attr_ok;
    logic [LINK_W-1:0] attr_link;

    always_comb begin
        attr_ok   = 1'b0;
        attr_link = '0;
        unique case (attr)
            ATTR_VGA: begin
                attr_ok   = vga_link_vld;
                attr_link = vga_link;
            end
            ATTR_CB: begin
                attr_ok   = cb_en;
                attr_link = cb_link;
            end
            ATTR_DND: begin
                attr_ok   = win_hit;
                attr_link = win_link;
            end
            ATTR_RSVD: begin
                attr_ok   = 1'b0;
                attr_link = '0;
            end
            default: begin
                attr_ok   = 1'b0;
                attr_link = '0;
            end
        endcase
        // Inbound I/O and configuration cycles never reach a link.
        go_fwd = attr_ok && !inbound && !is_cfg;
        link   = go_fwd ? attr_link : '0;
    end

endmodule

// File: rtl/ioroute_top.sv
module ioroute_top
    import ioroute_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LINK_W    = 2,
    parameter int BLK_SHIFT = 12,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_attr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_inbound,
    input  logic              req_cfg,
    input  logic [LINK_W-1:0] vga_link,
    input  logic              vga_link_vld,
    input  logic              cb_en,
    input  logic [LINK_W-1:0] cb_link,
    input  logic [BLK_W-1:0]  win_base,
    input  logic [BLK_W-1:0]  win_limit,
    input  logic [LINK_W-1:0] win_link,
    output logic              fwd_stb,
    output logic [LINK_W-1:0] fwd_link,
    output logic              abort_stb
);

    route_state_t      state, state_nxt;
    logic [LINK_W-1:0] link_q, link_nxt;
    logic              win_hit;
    logic              sel_fwd;
    logic [LINK_W-1:0] sel_link;

    ioroute_window #(
        .ADDR_W    (ADDR_W),
        .BLK_SHIFT (BLK_SHIFT)
    ) u_window (
        .addr      (req_addr),
        .base_blk  (win_base),
        .limit_blk (win_limit),
        .hit       (win_hit)
    );

    ioroute_select #(
        .LINK_W (LINK_W)
    ) u_select (
        .attr         (route_attr_t'(req_attr)),
        .inbound      (req_inbound),
        .is_cfg       (req_cfg),
        .vga_link     (vga_link),
        .vga_link_vld (vga_link_vld),
        .cb_en        (cb_en),
        .cb_link      (cb_link),
        .win_hit      (win_hit),
        .win_link     (win_link),
        .go_fwd       (sel_fwd),
        .link         (sel_link)
    );

    // Next-state decision: every accepted request lands in FWD or ABORT.
    always_comb begin
        state_nxt = RS_IDLE;
        link_nxt  = '0;
        if (req_valid) begin
            if (sel_fwd) begin
                state_nxt = RS_FWD;
                link_nxt  = sel_link;
            end else begin
                state_nxt = RS_ABORT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RS_IDLE;
            link_q <= '0;
        end else begin
            state  <= state_nxt;
            link_q <= link_nxt;
        end
    end

    always_comb begin
        fwd_stb   = 1'b0;
        abort_stb = 1'b0;
        fwd_link  = '0;
        unique case (state)
            RS_IDLE: ;
            RS_FWD: begin
                fwd_stb  = 1'b1;
                fwd_link = link_q;
            end
            RS_ABORT: abort_stb = 1'b1;
            default: ;
        endcase
    end

    // R2: never both strobes
    a_r2_excl_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_stb && abort_stb));
    // R2: an accepted request yields a strobe in the next cycle
    a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (fwd_stb || abort_stb));
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!fwd_stb && !abort_stb));
    a_r3_inbound_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_inbound) |=> abort_stb);
    a_r4_cfg_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cfg) |=> abort_stb);
    a_r5_vga_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_inbound && !req_cfg && req_attr == 2'b01 && vga_link_vld)
        |=> (fwd_stb && fwd_link == $past(vga_link)));
    a_r6_vga_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_attr == 2'b01 && !vga_link_vld) |=> abort_stb);
    a_r7_cb_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_inbound && !req_cfg && req_attr == 2'b10 && cb_en)
        |=> (fwd_stb && fwd_link == $past(cb_link)));
    a_r8_cb_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_attr == 2'b10 && !cb_en) |=> abort_stb);
    a_r10_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_attr == 2'b00 && win_base > win_limit) |=> abort_stb);
    a_r11_rsvd_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_attr == 2'b11) |=> abort_stb);
    a_r12_link_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_stb |-> (fwd_link == '0));

endmodule

// File: tb/test_ioroute_top.sv
module test_ioroute_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_attr = '0;
    logic [15:0] req_addr = '0;
    logic       req_inbound = 1'b0;
    logic       req_cfg = 1'b0;
    logic [1:0] vga_link = '0;
    logic       vga_link_vld = 1'b0;
    logic       cb_en = 1'b0;
    logic [1:0] cb_link = '0;
    logic [3:0] win_base = '0;
    logic [3:0] win_limit = '0;
    logic [1:0] win_link = '0;
    logic       fwd_stb;
    logic [1:0] fwd_link;
    logic       abort_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ioroute_top i_ioroute_top (
        .clk, .rst_n, .req_valid, .req_attr, .req_addr, .req_inbound, .req_cfg,
        .vga_link, .vga_link_vld, .cb_en, .cb_link, .win_base, .win_limit,
        .win_link, .fwd_stb, .fwd_link, .abort_stb
    );

    function automatic bit model_fwd();
        if (req_inbound) return 1'b0;
        if (req_cfg) return 1'b0;
        case (req_attr)
            2'b01: return vga_link_vld;
            2'b10: return cb_en;
            2'b00: return (req_addr[15:12] >= win_base) && (req_addr[15:12] <= win_limit);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] model_link();
        if (!model_fwd()) return 2'b00;
        case (req_attr)
            2'b01: return vga_link;
            2'b10: return cb_link;
            default: return win_link;
        endcase
    endfunction

    function automatic string model_tag();
        if (req_inbound) return "R3";
        if (req_cfg) return "R4";
        case (req_attr)
            2'b01: return vga_link_vld ? "R5" : "R6";
            2'b10: return cb_en ? "R7" : "R8";
            2'b00: return model_fwd() ? "R9" : "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input bit got_f, input bit got_a,
                         input logic [1:0] got_l, input bit exp_f, input bit exp_a,
                         input logic [1:0] exp_l);
        checks++;
        if (got_f !== exp_f || got_a !== exp_a || got_l !== exp_l) begin
            fails++;
            $display("FAIL %s: fwd=%0b abort=%0b link=%0d expected fwd=%0b abort=%0b link=%0d",
                     tag, got_f, got_a, got_l, exp_f, exp_a, exp_l);
        end
    endtask

    // Present one request, then check its response one cycle later (R2, R12).
    task automatic send(input logic [1:0] attr, input logic [15:0] addr,
                        input bit inb, input bit cfg);
        bit ef;
        logic [1:0] el;
        string tg;
        req_valid = 1'b1; req_attr = attr; req_addr = addr;
        req_inbound = inb; req_cfg = cfg;
        ef = model_fwd(); el = model_link(); tg = model_tag();
        @(negedge clk);
        check(tg, fwd_stb, abort_stb, fwd_link, ef, !ef, el);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check("R2", fwd_stb, abort_stb, fwd_link, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic set_cfg(input logic [1:0] vl, input bit vv, input bit ce,
                           input logic [1:0] cl, input logic [3:0] b,
                           input logic [3:0] l, input logic [1:0] wl);
        vga_link = vl; vga_link_vld = vv; cb_en = ce; cb_link = cl;
        win_base = b; win_limit = l; win_link = wl;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check("R1", fwd_stb, abort_stb, fwd_link, 1'b0, 1'b0, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", fwd_stb, abort_stb, fwd_link, 1'b0, 1'b0, 2'b00);

        set_cfg(2'd3, 1'b1, 1'b1, 2'd2, 4'd0, 4'd0, 2'd1);
        send(2'b01, 16'h03C0, 1'b0, 1'b0);   // R5
        send(2'b10, 16'h0060, 1'b0, 1'b0);   // R7
        send(2'b00, 16'h0ABC, 1'b0, 1'b0);   // R9 low 4 KB
        send(2'b01, 16'h03C0, 1'b1, 1'b0);   // R3
        send(2'b00, 16'h0CFC, 1'b0, 1'b1);   // R4
        send(2'b11, 16'h0000, 1'b0, 1'b0);   // R11
        idle();                              // R2, R12
        set_cfg(2'd3, 1'b0, 1'b0, 2'd2, 4'd4, 4'd9, 2'd2);
        send(2'b01, 16'h03B0, 1'b0, 1'b0);   // R6
        send(2'b10, 16'h0070, 1'b0, 1'b0);   // R8
        send(2'b00, 16'h4000, 1'b0, 1'b0);   // R9 base edge
        send(2'b00, 16'h9FFF, 1'b0, 1'b0);   // R9 limit edge
        send(2'b00, 16'h3FFF, 1'b0, 1'b0);   // R10 below base
        send(2'b00, 16'hA000, 1'b0, 1'b0);   // R10 above limit
        set_cfg(2'd1, 1'b1, 1'b1, 2'd1, 4'd8, 4'd7, 2'd3);
        send(2'b00, 16'h7800, 1'b0, 1'b0);   // R10 empty window
        send(2'b00, 16'h8000, 1'b0, 1'b0);   // R10 empty window
        idle();

        for (int i = 0; i < 4000; i++) begin
            set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                    4'($urandom), 4'($urandom), 2'($urandom));
            if ($urandom_range(0, 7) == 0) begin
                idle();
            end else begin
                send(2'($urandom), 16'($urandom),
                     ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
            end
        end
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule